// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of page translations for a 32-bit I/O virtual address space that uses 4 KiB pages. Every line carries an address-space identifier beside its virtual page number (VPN), so translations of several address spaces can live side by side. Each line also holds a physical frame number and three permission flags: readable, writable and nonsecure. A combinational lookup port takes an identifier and a VPN and returns a hit flag, the frame and the flags. A refill port installs one translation per cycle.

Invalidation is driven by one 32-bit command word. Its low two bits select how widely the addresses match: everything, one 4 MiB section, or one 16 KiB group of four pages. Its top bit optionally narrows the match to a single identifier. The identifier field sits just below that top bit, and its width follows the configured number of identifiers. A run-time count sets how many lines are in use, so a smaller cache can be tried without rebuilding the design.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits when a valid line among the active lines holds an identifier and a VPN equal to the lookup inputs. It then returns that line's frame. With no such line, the hit output is 0.
- R2: Command bits 1:0 give the address scope of an invalidation: 0 covers every address, 2 covers a 4 MiB section, 3 covers a 16 KiB group, and 1 removes no line.
- R3: When command bit 31 is 1, only lines whose identifier equals the command's identifier field are removed. That field is bits 30:24 when 128 identifiers are configured and bits 30:29 when 4 are configured. When bit 31 is 0, the identifier is not compared.
- R4: In section scope the command carries the virtual address shifted right by 12. A line matches when its VPN bits 19:10 equal command bits 19:10, which are virtual address bits 31:22.
- R5: In group scope a line matches when its VPN bits 19:2 equal command bits 19:2, which are virtual address bits 31:14. This covers four consecutive pages.
- R6: A hit returns the readable, writable and nonsecure flags that were stored with the line at refill.
- R7: Only the lowest N lines take part in lookup and refill, where N is the active-line count clamped to the number of lines. With N = 0, every refill is dropped.
- R8: An invalidation takes effect at the next clock edge. A refill presented in the same cycle is discarded.
- R9: A lookup made in the same cycle as an invalidation returns the result from before the invalidation. Removed lines miss from the next cycle on.
- R10: A refill goes to the lowest-numbered invalid active line. When every active line is valid, the victim is taken round-robin over the active lines.
- R11: A refill whose identifier and VPN already sit in an active valid line overwrites that line, so a key is never held twice.
- R12: After reset every line is invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgActive | input | CNT_W | Number of lines in use (clamped to NUM_LINES) |
| lkAsid | input | ASID_W | Lookup address-space identifier |
| lkVpn | input | 20 | Lookup virtual page number |
| lkHit | output | 1 | Lookup hit |
| lkPfn | output | PFN_W | Frame number of the hit line |
| lkRd | output | 1 | Readable flag of the hit line |
| lkWr | output | 1 | Writable flag of the hit line |
| lkNs | output | 1 | Nonsecure flag of the hit line |
| rfValid | input | 1 | Refill request |
| rfAsid | input | ASID_W | Refill identifier |
| rfVpn | input | 20 | Refill virtual page number |
| rfPfn | input | PFN_W | Refill frame number |
| rfRd | input | 1 | Refill readable flag |
| rfWr | input | 1 | Refill writable flag |
| rfNs | input | 1 | Refill nonsecure flag |
| flValid | input | 1 | Invalidation command strobe |
| flCmd | input | 32 | Invalidation command word |

## Verification
The bench builds two copies with four lines each. One copy uses 128 identifiers and the other uses 4. Both are driven from the same command word, so the two identifier-field positions are decoded side by side. Identifier values are chosen so that the wide field and the narrow field can name the same space or different ones. Four lines let the round-robin wrap, the invalid-first choice and the clamped active count be reached within a few refills. Random VPNs are drawn from a small pool that straddles section and group boundaries, so hits and partial invalidations occur often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int ASID_MAX_W = 7;
  localparam int SECT_LO    = 22 - PAGE_SHIFT;
  localparam int GRP_LO     = 14 - PAGE_SHIFT;
  localparam int QUAL_BIT   = 31;

  typedef enum logic [1:0] {
    SCOPE_ALL     = 2'd0,
    SCOPE_NONE    = 2'd1,
    SCOPE_SECTION = 2'd2,
    SCOPE_GROUP   = 2'd3
  } scope_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ns;
  } perm_t;

  typedef struct packed {
    logic                  killEn;
    logic                  killQual;
    logic [ASID_MAX_W-1:0] killAsid;
    scope_e                killScope;
    logic [VPN_W-1:0]      killVpn;
    logic                  fillEn;
  } strb_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ASID_W    = 7,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     cfgActive,
  input  logic                 flValid,
  input  logic [31:0]          flCmd,
  input  logic                 rfValid,
  input  logic [NUM_LINES-1:0] validVec,
  input  logic [NUM_LINES-1:0] rfHitVec,
  output strb_t                strb,
  output logic [IDX_W-1:0]     wrIdx,
  output logic [NUM_LINES-1:0] actMask
);
  logic [CNT_W-1:0]     effCnt;
  logic [IDX_W-1:0]     rrPtr;
  logic [IDX_W-1:0]     rrNext;
  logic [NUM_LINES-1:0] freeVec;
  logic                 useRr;

  function automatic logic [IDX_W-1:0] lowestSet(input logic [NUM_LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = NUM_LINES - 1; k >= 0; k--) begin
      if (v[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  always_comb begin
    effCnt = (cfgActive > CNT_W'(NUM_LINES)) ? CNT_W'(NUM_LINES) : cfgActive;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gAct
    assign actMask[g] = (CNT_W'(g) < effCnt);
  end

  assign freeVec = actMask & ~validVec;

  // command decode: identifier field sits just below the qualifier bit
  always_comb begin
    strb           = '0;
    strb.killEn    = flValid;
    strb.killQual  = flCmd[QUAL_BIT];
    strb.killAsid[ASID_W-1:0] = flCmd[QUAL_BIT-1 -: ASID_W];
    strb.killScope = scope_e'(flCmd[1:0]);
    strb.killVpn   = flCmd[VPN_W-1:0];
    strb.fillEn    = rfValid && !flValid && (effCnt != '0);
  end

  // victim choice: existing key, then lowest free line, then round-robin
  always_comb begin
    useRr = 1'b0;
    if (|rfHitVec) begin
      wrIdx = lowestSet(rfHitVec);
    end else if (|freeVec) begin
      wrIdx = lowestSet(freeVec);
    end else begin
      useRr = 1'b1;
      wrIdx = (CNT_W'(rrPtr) < effCnt) ? rrPtr : '0;
    end
    rrNext = ((CNT_W'(wrIdx) + CNT_W'(1)) >= effCnt) ? '0 : wrIdx + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strb.fillEn && useRr) begin
      rrPtr <= rrNext;
    end
  end

  AST_FILL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillEn |-> actMask[wrIdx]); // R7
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillEn && !(|rfHitVec) && (|freeVec)) |-> !validVec[wrIdx]); // R10
  AST_KEY_REUSE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillEn && (|rfHitVec)) |-> validVec[wrIdx]); // R11
endmodule

// File: rtl/tlb_data.sv
module tlb_data
  import tlb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ASID_W    = 7,
  parameter int PFN_W     = 20,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strb_t                strb,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [NUM_LINES-1:0] actMask,
  input  logic [ASID_W-1:0]    rfAsid,
  input  logic [VPN_W-1:0]     rfVpn,
  input  logic [PFN_W-1:0]     rfPfn,
  input  perm_t                rfPerm,
  input  logic [ASID_W-1:0]    lkAsid,
  input  logic [VPN_W-1:0]     lkVpn,
  output logic [NUM_LINES-1:0] validVec,
  output logic [NUM_LINES-1:0] rfHitVec,
  output logic                 lkHit,
  output logic [PFN_W-1:0]     lkPfn,
  output perm_t                lkPerm
);
  logic [NUM_LINES-1:0] vldQ;
  logic [ASID_W-1:0]    asidQ [NUM_LINES];
  logic [VPN_W-1:0]     vpnQ  [NUM_LINES];
  logic [PFN_W-1:0]     pfnQ  [NUM_LINES];
  perm_t                permQ [NUM_LINES];
  logic [NUM_LINES-1:0] kill;
  logic [NUM_LINES-1:0] lkHitVec;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic asidOk;
    logic addrOk;
    always_comb begin
      asidOk = !strb.killQual || (asidQ[g] == strb.killAsid[ASID_W-1:0]);
      case (strb.killScope)
        SCOPE_ALL:     addrOk = 1'b1;
        SCOPE_SECTION: addrOk = (vpnQ[g][VPN_W-1:SECT_LO] == strb.killVpn[VPN_W-1:SECT_LO]);
        SCOPE_GROUP:   addrOk = (vpnQ[g][VPN_W-1:GRP_LO] == strb.killVpn[VPN_W-1:GRP_LO]);
        default:       addrOk = 1'b0;
      endcase
    end
    assign kill[g]     = strb.killEn && asidOk && addrOk;
    assign lkHitVec[g] = vldQ[g] && actMask[g] && (asidQ[g] == lkAsid) && (vpnQ[g] == lkVpn);
    assign rfHitVec[g] = vldQ[g] && actMask[g] && (asidQ[g] == rfAsid) && (vpnQ[g] == rfVpn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ <= '0;
    end else begin
      for (int k = 0; k < NUM_LINES; k++) begin
        if (kill[k]) begin
          vldQ[k] <= 1'b0;
        end else if (strb.fillEn && (wrIdx == IDX_W'(k))) begin
          vldQ[k] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillEn) begin
      asidQ[wrIdx] <= rfAsid;
      vpnQ[wrIdx]  <= rfVpn;
      pfnQ[wrIdx]  <= rfPfn;
      permQ[wrIdx] <= rfPerm;
    end
  end

  always_comb begin
    lkPfn  = '0;
    lkPerm = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (lkHitVec[k]) begin
        lkPfn  = lkPfn | pfnQ[k];
        lkPerm = perm_t'(lkPerm | permQ[k]);
      end
    end
  end

  assign lkHit    = |lkHitVec;
  assign validVec = vldQ;

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkHitVec)); // R11
  AST_KILL_BLOCKS_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strb.killEn |=> ((vldQ & ~$past(vldQ)) == '0)); // R8
  AST_WIPE_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.killEn && !strb.killQual && (strb.killScope == SCOPE_ALL)) |=> (vldQ == '0)); // R2
  AST_NONE_SCOPE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.killEn && (strb.killScope == SCOPE_NONE)) |=> (vldQ == $past(vldQ))); // R2
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NUM_ASIDS = 128,
  parameter int PFN_W     = 20,
  localparam int ASID_W   = $clog2(NUM_ASIDS),
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CNT_W    = $clog2(NUM_LINES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cfgActive,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic              lkHit,
  output logic [PFN_W-1:0]  lkPfn,
  output logic              lkRd,
  output logic              lkWr,
  output logic              lkNs,
  input  logic              rfValid,
  input  logic [ASID_W-1:0] rfAsid,
  input  logic [VPN_W-1:0]  rfVpn,
  input  logic [PFN_W-1:0]  rfPfn,
  input  logic              rfRd,
  input  logic              rfWr,
  input  logic              rfNs,
  input  logic              flValid,
  input  logic [31:0]       flCmd
);
  strb_t                strb;
  logic [IDX_W-1:0]     wrIdx;
  logic [NUM_LINES-1:0] actMask;
  logic [NUM_LINES-1:0] validVec;
  logic [NUM_LINES-1:0] rfHitVec;
  perm_t                rfPerm;
  perm_t                lkPerm;

  assign rfPerm = '{rd: rfRd, wr: rfWr, ns: rfNs};

  tlb_ctrl #(
    .NUM_LINES(NUM_LINES), .ASID_W(ASID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgActive(cfgActive), .flValid(flValid), .flCmd(flCmd),
    .rfValid(rfValid), .validVec(validVec), .rfHitVec(rfHitVec),
    .strb(strb), .wrIdx(wrIdx), .actMask(actMask)
  );

  tlb_data #(
    .NUM_LINES(NUM_LINES), .ASID_W(ASID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .actMask(actMask),
    .rfAsid(rfAsid), .rfVpn(rfVpn), .rfPfn(rfPfn), .rfPerm(rfPerm),
    .lkAsid(lkAsid), .lkVpn(lkVpn), .validVec(validVec), .rfHitVec(rfHitVec),
    .lkHit(lkHit), .lkPfn(lkPfn), .lkPerm(lkPerm)
  );

  assign lkRd = lkPerm.rd;
  assign lkWr = lkPerm.wr;
  assign lkNs = lkPerm.ns;

  AST_RESET_MISS: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !lkHit); // R12
endmodule

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgActive = 3'd4;
  logic [6:0]  lkAsid = '0;
  logic [19:0] lkVpn = '0;
  logic        rfValid = 1'b0;
  logic [6:0]  rfAsid = '0;
  logic [19:0] rfVpn = '0;
  logic [19:0] rfPfn = '0;
  logic [2:0]  rfPerm = '0;
  logic        flValid = 1'b0;
  logic [31:0] flCmd = '0;

  logic        hit0, rd0, wr0, ns0, hit1, rd1, wr1, ns1;
  logic [19:0] pfn0, pfn1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  asid_tlb #(.NUM_LINES(4), .NUM_ASIDS(128), .PFN_W(20)) u0 (
    .clk(clk), .rstN(rstN), .cfgActive(cfgActive), .lkAsid(lkAsid), .lkVpn(lkVpn),
    .lkHit(hit0), .lkPfn(pfn0), .lkRd(rd0), .lkWr(wr0), .lkNs(ns0),
    .rfValid(rfValid), .rfAsid(rfAsid), .rfVpn(rfVpn), .rfPfn(rfPfn),
    .rfRd(rfPerm[2]), .rfWr(rfPerm[1]), .rfNs(rfPerm[0]), .flValid(flValid), .flCmd(flCmd)
  );

  asid_tlb #(.NUM_LINES(4), .NUM_ASIDS(4), .PFN_W(20)) u1 (
    .clk(clk), .rstN(rstN), .cfgActive(cfgActive), .lkAsid(lkAsid[1:0]), .lkVpn(lkVpn),
    .lkHit(hit1), .lkPfn(pfn1), .lkRd(rd1), .lkWr(wr1), .lkNs(ns1),
    .rfValid(rfValid), .rfAsid(rfAsid[1:0]), .rfVpn(rfVpn), .rfPfn(rfPfn),
    .rfRd(rfPerm[2]), .rfWr(rfPerm[1]), .rfNs(rfPerm[0]), .flValid(flValid), .flCmd(flCmd)
  );

  // reference model, one copy per instance (0: 128 ids, 1: 4 ids)
  logic        mVld  [2][4];
  logic [6:0]  mAsid [2][4];
  logic [19:0] mVpn  [2][4];
  logic [19:0] mPfn  [2][4];
  logic [2:0]  mPerm [2][4];
  int          mRr   [2];

  function automatic int effCnt();
    return (cfgActive > 3'd4) ? 4 : int'(cfgActive);
  endfunction

  function automatic logic [6:0] keyOf(int n, logic [6:0] a);
    return (n == 0) ? a : {5'b0, a[1:0]};
  endfunction

  function automatic logic [6:0] cmdId(int n, logic [31:0] c);
    return (n == 0) ? c[30:24] : {5'b0, c[30:29]};
  endfunction

  function automatic logic [23:0] modelLook(int n);
    for (int i = 0; i < effCnt(); i++) begin
      if (mVld[n][i] && mAsid[n][i] == keyOf(n, lkAsid) && mVpn[n][i] == lkVpn)
        return {1'b1, mPerm[n][i], mPfn[n][i]};
    end
    return '0;
  endfunction

  task automatic modelStep();
    for (int n = 0; n < 2; n++) begin
      if (flValid) begin
        for (int i = 0; i < 4; i++) begin
          logic idOk, adOk;
          idOk = !flCmd[31] || (mAsid[n][i] == cmdId(n, flCmd));
          case (flCmd[1:0])
            2'd0: adOk = 1'b1;
            2'd2: adOk = (mVpn[n][i][19:10] == flCmd[19:10]);
            2'd3: adOk = (mVpn[n][i][19:2] == flCmd[19:2]);
            default: adOk = 1'b0;
          endcase
          if (idOk && adOk) mVld[n][i] = 1'b0;
        end
      end else if (rfValid && effCnt() > 0) begin
        int idx;
        idx = -1;
        for (int i = 0; i < effCnt(); i++)
          if (idx < 0 && mVld[n][i] && mAsid[n][i] == keyOf(n, rfAsid) && mVpn[n][i] == rfVpn) idx = i;
        for (int i = 0; i < effCnt(); i++)
          if (idx < 0 && !mVld[n][i]) idx = i;
        if (idx < 0) begin
          idx = (mRr[n] < effCnt()) ? mRr[n] : 0;
          mRr[n] = (idx + 1 >= effCnt()) ? 0 : idx + 1;
        end
        mVld[n][idx]  = 1'b1;
        mAsid[n][idx] = keyOf(n, rfAsid);
        mVpn[n][idx]  = rfVpn;
        mPfn[n][idx]  = rfPfn;
        mPerm[n][idx] = rfPerm;
      end
    end
  endtask

  task automatic checkLook(string tag);
    for (int n = 0; n < 2; n++) begin
      logic [23:0] exp, act;
      exp = modelLook(n);
      act = (n == 0) ? {hit0, rd0, wr0, ns0, pfn0} : {hit1, rd1, wr1, ns1, pfn1};
      total++;
      if (exp[23] != act[23] || (exp[23] && exp != act)) begin
        bad++;
        $display("FAIL %s inst%0d asid=%h vpn=%h: actual=%h expected=%h", tag, n, lkAsid, lkVpn, act, exp);
      end
    end
  endtask

  // inputs are set after a rising edge; lookup checked at the falling edge
  task automatic step(string tag);
    @(negedge clk);
    checkLook(tag);
    @(posedge clk);
    #1;
    modelStep();
    rfValid = 1'b0;
    flValid = 1'b0;
  endtask

  task automatic look(logic [6:0] a, logic [19:0] v, string tag);
    lkAsid = a; lkVpn = v;
    step(tag);
  endtask

  task automatic fill(logic [6:0] a, logic [19:0] v, logic [19:0] p, logic [2:0] pm, string tag);
    rfValid = 1'b1; rfAsid = a; rfVpn = v; rfPfn = p; rfPerm = pm;
    step(tag);
  endtask

  task automatic kill(logic [31:0] c, string tag);
    flValid = 1'b1; flCmd = c;
    step(tag);
  endtask

  localparam logic [6:0] IDA = 7'h21; // narrow field reads 1 as well
  localparam logic [6:0] IDB = 7'h42; // narrow field reads 2 as well

  initial begin
    for (int n = 0; n < 2; n++) begin
      mRr[n] = 0;
      for (int i = 0; i < 4; i++) mVld[n][i] = 1'b0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    look(IDA, 20'h00401, "R12");
    fill(IDA, 20'h00400, 20'hAAAAA, 3'b101, "R6");
    fill(IDA, 20'h00401, 20'hBBBBB, 3'b110, "R6");
    fill(IDA, 20'h00404, 20'hCCCCC, 3'b011, "R6");
    fill(IDB, 20'h00400, 20'hDDDDD, 3'b111, "R6");
    look(IDA, 20'h00400, "R6");
    look(IDA, 20'h00401, "R1");
    look(IDB, 20'h00400, "R1");
    look(7'h01, 20'h00400, "R1");
    // group-scope, qualified: lookup during the command sees the old line
    lkAsid = IDA; lkVpn = 20'h00401;
    kill({1'b1, IDA, 4'h0, 20'h00403}, "R9");
    look(IDA, 20'h00401, "R9");
    look(IDA, 20'h00400, "R5");
    look(IDA, 20'h00404, "R5");
    look(IDB, 20'h00400, "R3");
    // section scope, unqualified
    kill(32'h0, "R2");
    fill(IDA, 20'h00800, 20'h11111, 3'b100, "R4");
    fill(IDB, 20'h00BFF, 20'h22222, 3'b010, "R4");
    fill(IDA, 20'h00C00, 20'h33333, 3'b001, "R4");
    fill(7'h01, 20'h00801, 20'h44444, 3'b111, "R4");
    kill(32'h0000_0802, "R4");
    look(IDA, 20'h00800, "R4");
    look(IDB, 20'h00BFF, "R4");
    look(IDA, 20'h00C00, "R4");
    // reserved scope removes nothing
    kill(32'hFFFF_FC01, "R2");
    look(IDA, 20'h00C00, "R2");
    // qualified wipe of one identifier only
    fill(IDB, 20'h00C00, 20'h55555, 3'b101, "R3");
    fill(7'h01, 20'h00C00, 20'h66666, 3'b011, "R3");
    kill({1'b1, IDA, 24'h0}, "R3");
    look(IDA, 20'h00C00, "R3");
    look(IDB, 20'h00C00, "R3");
    look(7'h01, 20'h00C00, "R3");
    // refill and command together: refill dropped
    rfValid = 1'b1; rfAsid = IDA; rfVpn = 20'h12345; rfPfn = 20'h77777; rfPerm = 3'b111;
    kill({1'b1, 7'h7F, 24'h3}, "R8");
    look(IDA, 20'h12345, "R8");
    kill(32'h0, "R2");
    look(IDB, 20'h00C00, "R2");
    // same key twice overwrites
    fill(IDA, 20'h00010, 20'h00001, 3'b100, "R11");
    fill(IDA, 20'h00010, 20'h00002, 3'b010, "R11");
    fill(IDA, 20'h00020, 20'h00003, 3'b001, "R11");
    fill(IDA, 20'h00030, 20'h00004, 3'b001, "R11");
    fill(IDA, 20'h00040, 20'h00005, 3'b001, "R11");
    look(IDA, 20'h00010, "R11");
    look(IDA, 20'h00040, "R11");
    // full: round-robin, then a hole is used first
    fill(IDB, 20'h00050, 20'h00006, 3'b110, "R10");
    fill(IDB, 20'h00060, 20'h00007, 3'b110, "R10");
    look(IDA, 20'h00010, "R10");
    look(IDA, 20'h00020, "R10");
    kill({1'b1, IDA, 4'h0, 20'h00043}, "R10");
    fill(IDB, 20'h00070, 20'h00008, 3'b011, "R10");
    look(IDA, 20'h00030, "R10");
    look(IDB, 20'h00070, "R10");
    // active-line count
    cfgActive = 3'd2;
    look(IDA, 20'h00030, "R7");
    fill(IDB, 20'h00080, 20'h00009, 3'b100, "R7");
    fill(IDB, 20'h00090, 20'h0000A, 3'b100, "R7");
    fill(IDB, 20'h000A0, 20'h0000B, 3'b100, "R7");
    look(IDB, 20'h00080, "R7");
    cfgActive = 3'd7;
    look(IDA, 20'h00030, "R7");
    cfgActive = 3'd0;
    fill(IDB, 20'h000B0, 20'h0000C, 3'b100, "R7");
    cfgActive = 3'd4;
    look(IDB, 20'h000B0, "R7");

    // random traffic
    for (int t = 0; t < 4000; t++) begin
      logic [31:0] r;
      logic [6:0]  id;
      r  = $urandom();
      id = (r[3:2] == 2'd0) ? IDA : (r[3:2] == 2'd1) ? IDB : {r[6:5], 3'b0, r[5:4]};
      lkAsid = (r[7]) ? IDA : id;
      lkVpn  = {9'h0, r[8], 6'h0, r[9], r[11:10], r[13:12]};
      if (r[19:16] < 4'd6) begin
        rfValid = 1'b1; rfAsid = id; rfPfn = $urandom(); rfPerm = r[22:20];
        rfVpn = {9'h0, r[23], 6'h0, r[24], r[26:25], r[28:27]};
      end
      if (r[31:29] == 3'd0 && r[15]) begin
        flValid = 1'b1;
        flCmd = {r[14], id, 4'h0, 9'h0, r[23], 6'h0, r[24], r[26:25], r[1:0]};
      end
      if (t % 500 == 499) cfgActive = 3'($urandom() % 5);
      step("R1");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule